// File: doc/BRIEF.md
# Speculative Register File with Deferred-Fault Tags

This block is a small integer register file for a pipeline that hoists instructions above branches. Each register word carries one extra tag bit that marks it as "poisoned". A speculative instruction that faults does not trap. Instead, its result write sets the tag on the destination register, and the fault waits there. If the speculation turns out to be unused and the register is overwritten or never read, no trap is ever reported. A correct program therefore sees no extra terminating exceptions.

The file has one write port and a paired read port with two operand indices. A read that a speculative consumer issues only reports the tags of its operands. A read from a non-speculative consumer that touches a tagged operand raises a one-cycle deferred-fault pulse together with the index of the offending register. A speculative write can also inherit the tag from its source registers, so poison follows a chain of speculative results. Register 0 is hard-wired to zero and is never tagged. All outputs are registered, and read results appear one cycle after the request.

Top module: `spec_poison_rf`

## Requirements
- R1: A synchronous active-high reset clears every register word and every tag and drives all outputs to zero. After reset, every register reads as zero and untagged.
- R2: A write with the fault flag low stores the data and clears the tag. Read results appear on the outputs in the cycle after the read request. A read and a write to the same register in the same cycle return the value held before the write. When no read is requested, the data and tag outputs hold their previous values.
- R3: A write with the fault flag high stores the data and sets the destination's tag.
- R4: A speculative write also sets the destination's tag when a source it names is tagged. Bit 0 of the source-use mask enables source A and bit 1 enables source B. A source whose mask bit is low is not consulted.
- R5: A non-speculative write never inherits tags from its sources. Its tag equals its fault flag.
- R6: A speculative read reports its operands' tags on the per-port tag outputs and never raises the deferred-fault pulse.
- R7: A non-speculative read with at least one tagged operand raises the deferred-fault valid output for exactly the cycle in which its results appear. The tagged register's index is shown alongside.
- R8: When both operands of a non-speculative read are tagged, the reported index is the one on operand port 0.
- R9: Register 0 ignores writes. It always reads as zero with its tag clear, even after a faulting write to it.
- R10: A tagged register that is never read by a non-speculative consumer causes no fault. Overwriting it with a non-faulting write removes the pending fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Destination register index |
| wr_data | input | DATA_W | Data to store |
| wr_spec | input | 1 | Writing instruction is speculative |
| wr_exc | input | 1 | Writing instruction faulted |
| wr_src_use | input | 2 | Source-use mask for tag inheritance (bit 0 source A, bit 1 source B) |
| wr_src_a | input | IDX_W | Source A index of the writing instruction |
| wr_src_b | input | IDX_W | Source B index of the writing instruction |
| rd_en | input | 1 | Read request |
| rd_spec | input | 1 | Reading instruction is speculative |
| rd0_idx | input | IDX_W | Operand port 0 index |
| rd1_idx | input | IDX_W | Operand port 1 index |
| rd0_data | output | DATA_W | Operand port 0 data |
| rd0_poison | output | 1 | Operand port 0 tag |
| rd1_data | output | DATA_W | Operand port 1 data |
| rd1_poison | output | 1 | Operand port 1 tag |
| dexc_valid | output | 1 | Deferred fault raised |
| dexc_idx | output | IDX_W | Index of the register that caused the fault |

## Verification
The assertions assume that every input is a known value at each clock edge from time zero. They also assume that the index inputs stay within the register count. In particular, a read request and its speculative flag must be defined during reset, because the checks look one cycle back at them. The bench drives every input to a defined idle value before the first edge. It changes inputs only on falling edges and uses indices below the register count, so the history those checks examine is always defined.

// File: rtl/spr_pkg.sv
package spr_pkg;
  // positions inside the source-use mask of a write
  localparam int SRC_A_BIT = 0;
  localparam int SRC_B_BIT = 1;
  localparam int SRC_N     = 2;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_PORT0 = 2'b01,
    FLT_PORT1 = 2'b10
  } fault_src_e;

  // port 0 has precedence over port 1
  function automatic fault_src_e pick_fault(input logic p0, input logic p1);
    if (p0)      return FLT_PORT0;
    else if (p1) return FLT_PORT1;
    else         return FLT_NONE;
  endfunction
endpackage

// File: rtl/spr_data_bank.sv
module spr_data_bank #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd0_data,
  output logic [DATA_W-1:0] rd1_data
);
  logic [DATA_W-1:0] words [NREGS];

  genvar g;
  generate
    for (g = 0; g < NREGS; g++) begin : g_word
      if (g == 0) begin : g_zero
        assign words[g] = '0;
      end else begin : g_store
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
          if (rst)
            q <= '0;
          else if (wr_en && (wr_idx == IDX_W'(g)))
            q <= wr_data;
        end
        assign words[g] = q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0_data <= '0;
      rd1_data <= '0;
    end else if (rd_en) begin
      rd0_data <= words[rd0_idx];
      rd1_data <= words[rd1_idx];
    end
  end
endmodule

// File: rtl/spr_poison_track.sv
module spr_poison_track #(
  parameter int NREGS = 32,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_spec,
  input  logic             wr_exc,
  input  logic [1:0]       wr_src_use,
  input  logic [IDX_W-1:0] wr_src_a,
  input  logic [IDX_W-1:0] wr_src_b,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [IDX_W-1:0] rd1_idx,
  output logic             p0_now,
  output logic             p1_now,
  output logic             rd0_poison,
  output logic             rd1_poison
);
  import spr_pkg::*;

  logic tags [NREGS];
  logic inherit;
  logic tag_next;

  // poison follows speculative chains only
  always_comb begin
    inherit = 1'b0;
    if (wr_spec) begin
      if (wr_src_use[SRC_A_BIT] && tags[wr_src_a]) inherit = 1'b1;
      if (wr_src_use[SRC_B_BIT] && tags[wr_src_b]) inherit = 1'b1;
    end
    tag_next = wr_exc | inherit;
  end

  genvar g;
  generate
    for (g = 0; g < NREGS; g++) begin : g_tag
      if (g == 0) begin : g_zero
        assign tags[g] = 1'b0;
      end else begin : g_flop
        logic q;
        always_ff @(posedge clk) begin
          if (rst)
            q <= 1'b0;
          else if (wr_en && (wr_idx == IDX_W'(g)))
            q <= tag_next;
        end
        assign tags[g] = q;
      end
    end
  endgenerate

  assign p0_now = tags[rd0_idx];
  assign p1_now = tags[rd1_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0_poison <= 1'b0;
      rd1_poison <= 1'b0;
    end else if (rd_en) begin
      rd0_poison <= p0_now;
      rd1_poison <= p1_now;
    end
  end
endmodule

// File: rtl/spr_exc_report.sv
module spr_exc_report #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             rd_spec,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic             p0_now,
  input  logic             p1_now,
  output logic             dexc_valid,
  output logic [IDX_W-1:0] dexc_idx
);
  import spr_pkg::*;

  fault_src_e which;
  logic       raise;

  always_comb begin
    which = pick_fault(p0_now, p1_now);
    raise = rd_en && !rd_spec && (which != FLT_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dexc_valid <= 1'b0;
      dexc_idx   <= '0;
    end else begin
      dexc_valid <= raise;
      if (raise)
        dexc_idx <= (which == FLT_PORT0) ? rd0_idx : rd1_idx;
    end
  end
endmodule

// File: rtl/spec_poison_rf.sv
module spec_poison_rf #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_spec,
  input  logic              wr_exc,
  input  logic [1:0]        wr_src_use,
  input  logic [IDX_W-1:0]  wr_src_a,
  input  logic [IDX_W-1:0]  wr_src_b,
  input  logic              rd_en,
  input  logic              rd_spec,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_poison,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_poison,
  output logic              dexc_valid,
  output logic [IDX_W-1:0]  dexc_idx
);
  logic p0_now, p1_now;

  spr_data_bank #(.NREGS(NREGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
    .rd0_data(rd0_data), .rd1_data(rd1_data)
  );

  spr_poison_track #(.NREGS(NREGS), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_spec(wr_spec), .wr_exc(wr_exc),
    .wr_src_use(wr_src_use), .wr_src_a(wr_src_a), .wr_src_b(wr_src_b),
    .rd_en(rd_en), .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
    .p0_now(p0_now), .p1_now(p1_now),
    .rd0_poison(rd0_poison), .rd1_poison(rd1_poison)
  );

  spr_exc_report #(.IDX_W(IDX_W)) u_exc (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_spec(rd_spec),
    .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
    .p0_now(p0_now), .p1_now(p1_now),
    .dexc_valid(dexc_valid), .dexc_idx(dexc_idx)
  );
endmodule

// File: rtl/spec_poison_rf_checker.sv
module spec_poison_rf_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              rd_spec,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [DATA_W-1:0] rd0_data,
  input logic              rd0_poison,
  input logic              rd1_poison,
  input logic              dexc_valid,
  input logic [IDX_W-1:0]  dexc_idx
);
  p_spec_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && rd_spec) |-> !dexc_valid);

  p_fault_cause_r7: assert property (@(posedge clk) disable iff (rst)
    dexc_valid |-> ($past(rd_en && !rd_spec) && (rd0_poison || rd1_poison)));

  p_port0_first_r8: assert property (@(posedge clk) disable iff (rst)
    (dexc_valid && rd0_poison) |-> (dexc_idx == $past(rd0_idx)));

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && (rd0_idx == '0)) |-> (!rd0_poison && (rd0_data == '0)));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !dexc_valid);
endmodule

bind spec_poison_rf spec_poison_rf_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_spec(rd_spec),
  .rd0_idx(rd0_idx), .rd0_data(rd0_data),
  .rd0_poison(rd0_poison), .rd1_poison(rd1_poison),
  .dexc_valid(dexc_valid), .dexc_idx(dexc_idx)
);

// File: tb/spec_poison_rf_bench.sv
module spec_poison_rf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS  = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_spec = 1'b0, wr_exc = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0, wr_src_a = '0, wr_src_b = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0] wr_src_use = 2'b00;
  logic rd_en = 1'b0, rd_spec = 1'b0;
  logic [IDX_W-1:0] rd0_idx = '0, rd1_idx = '0;
  logic [DATA_W-1:0] rd0_data, rd1_data;
  logic rd0_poison, rd1_poison, dexc_valid;
  logic [IDX_W-1:0] dexc_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_poison_rf #(.NREGS(NREGS), .DATA_W(DATA_W)) u_spec_poison_rf (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_spec(wr_spec), .wr_exc(wr_exc), .wr_src_use(wr_src_use),
    .wr_src_a(wr_src_a), .wr_src_b(wr_src_b),
    .rd_en(rd_en), .rd_spec(rd_spec), .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
    .rd0_data(rd0_data), .rd0_poison(rd0_poison),
    .rd1_data(rd1_data), .rd1_poison(rd1_poison),
    .dexc_valid(dexc_valid), .dexc_idx(dexc_idx)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one write, presented for exactly one rising edge
  task automatic wr(input int idx, input logic [DATA_W-1:0] d, input logic spec, input logic exc,
                    input logic [1:0] use_m, input int sa, input int sb);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d; wr_spec = spec; wr_exc = exc;
    wr_src_use = use_m; wr_src_a = IDX_W'(sa); wr_src_b = IDX_W'(sb);
    @(negedge clk);
    wr_en = 1'b0; wr_spec = 1'b0; wr_exc = 1'b0; wr_src_use = 2'b00;
  endtask

  // one read; outputs are sampled one edge later, at the following falling edge
  task automatic rd(input int i0, input int i1, input logic spec);
    rd_en = 1'b1; rd_spec = spec; rd0_idx = IDX_W'(i0); rd1_idx = IDX_W'(i1);
    @(negedge clk);
    rd_en = 1'b0; rd_spec = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "dexc_valid", 64'(dexc_valid), 0);
    check("R1", "rd0_data", 64'(rd0_data), 0);
    check("R1", "rd1_poison", 64'(rd1_poison), 0);
    rd(17, 31, 1'b0);
    check("R1", "data after reset", 64'({rd0_data, rd1_data}), 0);
    check("R1", "tags after reset", 64'({rd0_poison, rd1_poison, dexc_valid}), 0);
  endtask

  task automatic t_plain_write;
    wr(3, 32'h1234_5678, 1'b0, 1'b0, 2'b00, 0, 0);
    wr(4, 32'hCAFE_0004, 1'b1, 1'b0, 2'b00, 0, 0);
    rd(3, 4, 1'b0);
    check("R2", "r3 data", 64'(rd0_data), 64'h1234_5678);
    check("R2", "r4 data", 64'(rd1_data), 64'hCAFE_0004);
    check("R2", "clean tags", 64'({rd0_poison, rd1_poison, dexc_valid}), 0);
    // idle cycle: outputs hold
    @(negedge clk);
    check("R2", "hold without read", 64'(rd0_data), 64'h1234_5678);
    // same-cycle read and write returns old value
    wr_en = 1'b1; wr_idx = 3; wr_data = 32'h0BAD_F00D; wr_spec = 1'b0; wr_exc = 1'b0;
    rd_en = 1'b1; rd_spec = 1'b0; rd0_idx = 3; rd1_idx = 0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R2", "read before write", 64'(rd0_data), 64'h1234_5678);
    rd(3, 0, 1'b1);
    check("R2", "new value visible", 64'(rd0_data), 64'h0BAD_F00D);
  endtask

  task automatic t_fault_write;
    wr(5, 32'h5555_0005, 1'b1, 1'b1, 2'b00, 0, 0);
    rd(5, 3, 1'b1);
    check("R3", "r5 tag", 64'(rd0_poison), 1);
    check("R3", "r5 data", 64'(rd0_data), 64'h5555_0005);
  endtask

  task automatic t_spec_inherit;
    wr(7, 32'h7, 1'b1, 1'b0, 2'b01, 5, 3);
    wr(8, 32'h8, 1'b1, 1'b0, 2'b10, 5, 5);
    wr(9, 32'h9, 1'b1, 1'b0, 2'b10, 5, 3);
    rd(7, 8, 1'b1);
    check("R4", "inherit via src A", 64'(rd0_poison), 1);
    check("R4", "inherit via src B", 64'(rd1_poison), 1);
    rd(9, 0, 1'b1);
    check("R4", "masked source ignored", 64'(rd0_poison), 0);
  endtask

  task automatic t_nonspec_no_inherit;
    wr(10, 32'hA, 1'b0, 1'b0, 2'b11, 5, 7);
    rd(10, 0, 1'b0);
    check("R5", "non-spec write clean", 64'(rd0_poison), 0);
    check("R5", "no fault", 64'(dexc_valid), 0);
  endtask

  task automatic t_spec_read;
    rd(5, 7, 1'b1);
    check("R6", "tags reported", 64'({rd0_poison, rd1_poison}), 2'b11);
    check("R6", "no fault on spec read", 64'(dexc_valid), 0);
  endtask

  task automatic t_nonspec_fault;
    rd(3, 5, 1'b0);
    check("R7", "fault raised", 64'(dexc_valid), 1);
    check("R7", "fault index", 64'(dexc_idx), 5);
    @(negedge clk);
    check("R7", "single-cycle pulse", 64'(dexc_valid), 0);
  endtask

  task automatic t_both_ports;
    rd(8, 5, 1'b0);
    check("R8", "fault raised", 64'(dexc_valid), 1);
    check("R8", "port 0 wins", 64'(dexc_idx), 8);
  endtask

  task automatic t_zero_reg;
    wr(0, 32'hFFFF_FFFF, 1'b1, 1'b1, 2'b00, 0, 0);
    rd(0, 0, 1'b0);
    check("R9", "r0 data", 64'({rd0_data, rd1_data}), 0);
    check("R9", "r0 tag and fault", 64'({rd0_poison, dexc_valid}), 0);
  endtask

  task automatic t_unread;
    wr(12, 32'hC, 1'b1, 1'b1, 2'b00, 0, 0);
    rd(3, 4, 1'b0);
    check("R10", "unread tag no fault", 64'(dexc_valid), 0);
    wr(12, 32'hC0C0, 1'b0, 1'b0, 2'b00, 0, 0);
    rd(12, 0, 1'b0);
    check("R10", "overwrite clears fault", 64'({rd0_poison, dexc_valid}), 0);
    check("R10", "new data", 64'(rd0_data), 64'hC0C0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain_write();
    t_fault_write();
    t_spec_inherit();
    t_nonspec_no_inherit();
    t_spec_read();
    t_nonspec_fault();
    t_both_ports();
    t_zero_reg();
    t_unread();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule